// File: doc/BRIEF.md
# Output Reference Ramp Generator

This block produces the reference code that feeds the output-voltage DAC of a buck regulator. One code step is 25 mV, so a code of N asks for N × 25 mV. Software commits a new setpoint code with a one-cycle load strobe. The block clamps that code into the legal window and moves its reference output toward the clamped target. A rise in the reference is paced by a 1 µs tick. A fall takes effect at once.

While the start input is low, the reference is held at zero. When start goes high, the block waits a fixed initialization interval. It then soft-starts from zero toward the target at the power-on default slew. After that first settle, every later upward change uses the slew chosen by the rate select. When the committed code is out of range, the block clamps it and pulses an under-range or over-range flag for one cycle, so that a flag register elsewhere can latch it.

Top module: `vout_ref_ramp`

## Requirements
- R1: The target is the committed code clamped to the range 16..215 (0.4 V to 5.375 V at 25 mV per code). The reference output never exceeds 215 and settles on the clamped value.
- R2: A load with a code below 16 raises `under_o` for exactly the one cycle after the load edge. A load with a code above 215 does the same on `over_o`. Codes 16 and 215 raise neither flag, and the two flags are never high together.
- R3: While `start_i` is low, `ref_o` is 0 and `done_o` is 0. Dropping `start_i` returns `ref_o` to 0 on the next clock.
- R4: After `start_i` rises, `ref_o` stays 0 for 125 ticks before the soft-start ramp may begin.
- R5: The soft-start ramp rises one code every 8 ticks, whatever the value of `rate_sel_i`.
- R6: After the first settle, an upward change rises one code every 8, 4, 32 or 16 ticks for `rate_sel_i` = 0, 1, 2 or 3 respectively.
- R7: `ref_o` rises by at most one code at a time, and only on a clock where `tick_i` was high.
- R8: When the target is below the current reference, `ref_o` equals the target on the clock after the target register updates, which is two edges after the load strobe.
- R9: A new higher target committed mid-ramp does not restart the step timer. The ramp continues from the present reference on its existing schedule.
- R10: `done_o` is high exactly when the ramp is active (after initialization) and `ref_o` equals the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every microsecond |
| start_i | input | 1 | Enable and supply-good; low forces the reference to zero |
| vset_load_i | input | 1 | Strobe that commits `vset_i` |
| vset_i | input | 8 | Requested output code, 25 mV per LSB |
| rate_sel_i | input | 2 | Slew for upward changes after soft-start: 0=8, 1=4, 2=32, 3=16 µs per code |
| ref_o | output | 8 | Current reference code |
| done_o | output | 1 | Reference has reached the target |
| under_o | output | 1 | One-cycle pulse: committed code was below range |
| over_o | output | 1 | One-cycle pulse: committed code was above range |

## Verification
The hardest case to reach is a retarget that lands between two step ticks of an ongoing ramp. There, a wrongly cleared step timer only shows up as a single step arriving late. The stimulus loads a higher target partway through a step period, with no tick in between, and then compares the reference after the remaining ticks with the count from the original schedule. The clamp is swept over all 256 codes in descending order. Each new target is then at or below the last one, so the clamped value appears on the reference at once, without waiting out a ramp.

// File: rtl/vref_ramp_pkg.sv
package vref_ramp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_SOFT, ST_RUN} ramp_st_e;

  // log2 of microseconds per code step: sel 0..3 -> 8,4,32,16
  function automatic logic [2:0] rate_log2(input logic [1:0] sel);
    return 3'd3 - {2'd0, sel[0]} + (sel[1] ? 3'd2 : 3'd0);
  endfunction
endpackage

// File: rtl/vref_clamp.sv
module vref_clamp #(
  parameter int CODE_W   = 8,
  parameter int CODE_MIN = 16,
  parameter int CODE_MAX = 215
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              low_o,
  output logic              high_o
);
  localparam logic [CODE_W-1:0] LO = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] HI = CODE_W'(CODE_MAX);

  always_comb begin
    low_o  = code_i < LO;
    high_o = code_i > HI;
    if (low_o)       code_o = LO;
    else if (high_o) code_o = HI;
    else             code_o = code_i;
  end
endmodule

// File: rtl/vref_pacer.sv
module vref_pacer #(
  parameter int MAX_LOG2 = 5,
  localparam int CNT_W   = MAX_LOG2 + 1,
  localparam int LOG_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [LOG_W-1:0] log2_i,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = (CNT_W'(1) << log2_i) - CNT_W'(1);
  // >= so a slower-to-faster rate change mid-period steps on the next tick
  assign step_o = run_i && tick_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= step_o ? '0 : cnt_q + CNT_W'(1);
  end

  // R6: the timer never outgrows the slowest period
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < (CNT_W'(1) << MAX_LOG2));
  // R9: the timer only clears on a step or when the ramp stops
  p_cnt_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> (cnt_q == $past(cnt_q)) || !$past(run_i));
endmodule

// File: rtl/vout_ref_ramp.sv
module vout_ref_ramp
  import vref_ramp_pkg::*;
#(
  parameter int          CODE_W    = 8,
  parameter int          CODE_MIN  = 16,
  parameter int          CODE_MAX  = 215,
  parameter int          DEF_CODE  = 72,
  parameter int          INIT_US   = 125,
  parameter logic [1:0]  SOFT_RATE = 2'd0,
  localparam int         INIT_W    = $clog2(INIT_US + 1),
  localparam int         MAX_LOG2  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              vset_load_i,
  input  logic [CODE_W-1:0] vset_i,
  input  logic [1:0]        rate_sel_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              done_o,
  output logic              under_o,
  output logic              over_o
);
  ramp_st_e          st_q;
  logic [INIT_W-1:0] icnt_q;
  logic [CODE_W-1:0] tgt_q, ref_q, clamp_code;
  logic              clamp_lo, clamp_hi, under_q, over_q;
  logic              active, run, step;
  logic [2:0]        log2_sel;

  vref_clamp #(.CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) u_clamp (
    .code_i(vset_i), .code_o(clamp_code), .low_o(clamp_lo), .high_o(clamp_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= CODE_W'(DEF_CODE);
      under_q <= 1'b0;
      over_q  <= 1'b0;
    end else begin
      under_q <= vset_load_i && clamp_lo;
      over_q  <= vset_load_i && clamp_hi;
      if (vset_load_i) tgt_q <= clamp_code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      icnt_q <= '0;
    end else if (!start_i) begin
      st_q   <= ST_IDLE;
      icnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: st_q <= ST_INIT;
        ST_INIT: if (tick_i) begin
          if (icnt_q == INIT_W'(INIT_US - 1)) st_q <= ST_SOFT;
          icnt_q <= icnt_q + INIT_W'(1);
        end
        ST_SOFT: if (ref_q == tgt_q) st_q <= ST_RUN;
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign active   = (st_q == ST_SOFT) || (st_q == ST_RUN);
  assign run      = start_i && active && (ref_q < tgt_q);
  assign log2_sel = (st_q == ST_RUN) ? rate_log2(rate_sel_i) : rate_log2(SOFT_RATE);

  vref_pacer #(.MAX_LOG2(MAX_LOG2)) u_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_i(tick_i),
    .log2_i(log2_sel), .step_o(step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ref_q <= '0;
    else if (!start_i)                   ref_q <= '0;
    else if (active && tgt_q < ref_q)    ref_q <= tgt_q;
    else if (step)                       ref_q <= ref_q + CODE_W'(1);
  end

  assign ref_o   = ref_q;
  assign done_o  = active && (ref_q == tgt_q);
  assign under_o = under_q;
  assign over_o  = over_q;

  p_tgt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_q >= CODE_W'(CODE_MIN) && tgt_q <= CODE_W'(CODE_MAX));
  p_ref_max_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o <= CODE_W'(CODE_MAX));
  p_flag_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(under_o && over_o));
  p_under_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    under_o |-> $past(vset_load_i) && $past(vset_i) < CODE_W'(CODE_MIN));
  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (ref_o == '0) && !done_o);
  p_init_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INIT) |-> ref_o == '0);
  p_rise_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o > $past(ref_o)) |-> $past(tick_i) && ref_o == $past(ref_o) + CODE_W'(1));
  p_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && active && tgt_q < ref_q) |=> ref_o == $past(tgt_q) || !$past(start_i));
endmodule

// File: tb/vout_ref_ramp_tb.sv
module vout_ref_ramp_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, start = 1'b0, load = 1'b0;
  logic [7:0] vset = 8'd0;
  logic [1:0] rsel = 2'd0;
  logic [7:0] ref_c;
  logic       done, under, over;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vout_ref_ramp u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .start_i(start),
    .vset_load_i(load), .vset_i(vset), .rate_sel_i(rsel),
    .ref_o(ref_c), .done_o(done), .under_o(under), .over_o(over)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
  endtask

  task automatic do_load(input int c);
    vset = 8'(c); load = 1'b1; @(negedge clk); load = 1'b0;
  endtask

  function automatic int clampf(input int c);
    return c < 16 ? 16 : (c > 215 ? 215 : c);
  endfunction

  function automatic int period(input int r);
    case (r) 0: return 8; 1: return 4; 2: return 32; default: return 16; endcase
  endfunction

  function automatic int minf(input int a, input int b);
    return a < b ? a : b;
  endfunction

  initial begin
    #(5ns * 190000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cur, tgt, p, e;
    repeat (3) @(negedge clk);
    chk(ref_c == 0 && !done && !under && !over, "R3 reset state", ref_c, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 in-range load while idle: no flags
    do_load(72);
    chk(!under && !over, "R2 in-range no flag", {under, over}, 0);
    rsel = 2'd2;
    start = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 125; k++) begin
      do_tick();
      chk(ref_c == 0, "R4 init hold", ref_c, 0);
    end
    // R5 soft-start at 8 ticks/code despite rsel=2
    for (int k = 1; k <= 72 * 8 + 4; k++) begin
      do_tick();
      e = minf(72, k / 8);
      chk(ref_c == 8'(e), "R5 soft-start ramp", ref_c, e);
      chk(done == (e == 72), "R10 done tracks", done, e == 72);
    end
    // R6 each rate after settle
    cur = 72;
    for (int r = 0; r < 4; r++) begin
      rsel = 2'(r);
      p = period(r);
      tgt = cur + 5;
      do_load(tgt);
      for (int k = 1; k <= 5 * p + 2; k++) begin
        do_tick();
        e = minf(tgt, cur + k / p);
        chk(ref_c == 8'(e), "R6 rate ramp", ref_c, e);
      end
      chk(done, "R10 done after rate ramp", done, 1);
      cur = tgt;
    end
    // R1 over-range clamp and ramp to ceiling
    rsel = 2'd1;
    do_load(250);
    chk(over && !under, "R2 over pulse", over, 1);
    @(negedge clk);
    chk(!over, "R2 over one cycle", over, 0);
    for (int k = 1; k <= (215 - cur) * 4 + 4; k++) begin
      do_tick();
      e = minf(215, cur + k / 4);
      chk(ref_c == 8'(e), "R1 ramp to clamp", ref_c, e);
    end
    // R1/R2/R8 exhaustive descending clamp sweep
    for (int c = 255; c >= 0; c--) begin
      do_load(c);
      chk(under == (c < 16) && over == (c > 215), "R2 flag sweep", {under, over}, {c < 16, c > 215});
      @(negedge clk);
      chk(ref_c == 8'(clampf(c)), "R8 drop to clamp", ref_c, clampf(c));
      chk(!under && !over, "R2 flags clear", {under, over}, 0);
    end
    // R9 retarget mid-ramp keeps schedule
    rsel = 2'd0;
    do_load(30);
    for (int k = 1; k <= 12; k++) do_tick();
    chk(ref_c == 17, "R9 before retarget", ref_c, 17);
    do_load(40);
    @(negedge clk);
    for (int k = 1; k <= 4; k++) do_tick();
    chk(ref_c == 18, "R9 after retarget", ref_c, 18);
    chk(!done, "R10 not done mid ramp", done, 0);
    // R3 start drop
    start = 1'b0;
    @(negedge clk);
    chk(ref_c == 0 && !done, "R3 drop start", ref_c, 0);
    do_tick();
    chk(ref_c == 0, "R3 ticks ignored idle", ref_c, 0);
    // R4/R5 restart with rsel=3
    rsel = 2'd3;
    start = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 125; k++) do_tick();
    chk(ref_c == 0, "R4 restart init", ref_c, 0);
    for (int k = 1; k <= 7; k++) do_tick();
    chk(ref_c == 0, "R5 restart 7 ticks", ref_c, 0);
    do_tick();
    chk(ref_c == 1, "R5 restart 8 ticks", ref_c, 1);
    // R7 no rise without tick
    repeat (20) @(negedge clk);
    chk(ref_c == 1, "R7 no tick no rise", ref_c, 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule